// File: doc/BRIEF.md
# Wakeup-Select Issue Queue

This block holds dispatched instructions until both of their source operands are available and then sends them to execution, one per cycle. Each of its eight slots keeps two source tags with a readiness flag for each, a destination tag, an occupancy flag, an issued flag and a relative age. An instruction is written into a free slot chosen by the dispatch logic. Every slot compares its pending source tags against two wakeup tags each cycle. One is the external result tag input. The other is the destination tag of the instruction the queue is granting in that cycle.

Among the slots that are occupied, not yet issued and fully ready, the grant goes to the one with the lowest age, which is the one dispatched earliest. Slot position plays no part. A granted slot is marked issued but stays occupied until the dealloc input frees it. When a slot is freed, every younger slot moves one step closer to the front, so the ages of occupied slots always run from 0 to one less than the number of occupied slots.

Top module: `wakeup_select_iq`

## Requirements
- R1: After reset, and during a reset asserted in mid-operation, all slots are empty and issueValid is 0.
- R2: A dispatch with both ready flags set makes that slot a bidder in the next cycle: with no other bidder, issueValid is 1, issueSlot is the slot number and issueDst is its destination tag.
- R3: A slot with an operand not ready does not bid until a broadcast tag (bcastValid = 1) equal to that source tag is seen. It bids in the cycle after that broadcast.
- R4: A slot with only one of its two operands ready never bids.
- R5: When several slots bid, the grant goes to the one dispatched earliest among the occupied slots, whatever its slot number.
- R6: A bidding slot that loses keeps bidding and is granted in a later cycle, in age order.
- R7: A granted slot is marked issued and is never granted again until it is freed and dispatched anew.
- R8: The destination tag of the granted instruction wakes matching source operands, so a dependent whose other operand is ready is granted in the very next cycle.
- R9: A broadcast in the same cycle as a dispatch is captured by the new slot's matching operand.
- R10: Freeing a slot (freeValid = 1, freeSlot = its number) empties it, and the age order of the remaining slots is kept. A slot dispatched later is younger than all remaining slots, even at a lower slot number.
- R11: When no slot bids, issueValid is 0 and issueSlot and issueDst are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | Write one instruction this cycle |
| dispSlot | input | 3 | Free slot to write |
| dispSrcL | input | 6 | Left source tag |
| dispRdyL | input | 1 | Left operand already available |
| dispSrcR | input | 6 | Right source tag |
| dispRdyR | input | 1 | Right operand already available |
| dispDst | input | 6 | Destination tag |
| bcastValid | input | 1 | External result tag is valid |
| bcastTag | input | 6 | External result tag |
| freeValid | input | 1 | Free one slot this cycle |
| freeSlot | input | 3 | Slot to free |
| issueValid | output | 1 | A slot is granted this cycle |
| issueSlot | output | 3 | Granted slot |
| issueDst | output | 6 | Destination tag of the granted slot |

## Verification
The bench goes after age ordering that contradicts slot position: the oldest bidder sits at the highest slot number, and later a freshly dispatched slot at slot 0 must lose to an older one at slot 2. A design that picks by slot index, or that does not renumber ages on free, grants the wrong slot there. It also checks capture of a broadcast in the same cycle as a dispatch, and back-to-back wakeup from the granted destination tag. A design that misses the first never issues the slot. One that misses the second issues the dependent late or never. Half-ready slots and already issued slots must stay silent, or a spurious issue appears.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_DEPTH = 8;
  localparam int IQ_TAG_W = 6;
  localparam int SLOT_W   = $clog2(IQ_DEPTH);
  localparam int AGE_W    = SLOT_W;

  // strobes from select control to the entry datapath
  typedef struct packed {
    logic              grantValid;
    logic [SLOT_W-1:0] grantSlot;
  } iqStrobe_t;
endpackage

// File: rtl/iq_entries.sv
module iq_entries
  import iq_pkg::*;
#(
  parameter int DEPTH = IQ_DEPTH,
  parameter int TAG_W = IQ_TAG_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dispValid,
  input  logic [SLOT_W-1:0]            dispSlot,
  input  logic [TAG_W-1:0]             dispSrcL,
  input  logic                         dispRdyL,
  input  logic [TAG_W-1:0]             dispSrcR,
  input  logic                         dispRdyR,
  input  logic [TAG_W-1:0]             dispDst,
  input  logic                         bcastValid,
  input  logic [TAG_W-1:0]             bcastTag,
  input  logic                         freeValid,
  input  logic [SLOT_W-1:0]            freeSlot,
  input  iqStrobe_t                    strobe,
  output logic [DEPTH-1:0]             bidVec,
  output logic [DEPTH-1:0][AGE_W-1:0]  ageVec,
  output logic [TAG_W-1:0]             grantDst
);
  typedef struct packed {
    logic             valid;
    logic             issued;
    logic             rdyL;
    logic             rdyR;
    logic [TAG_W-1:0] srcL;
    logic [TAG_W-1:0] srcR;
    logic [TAG_W-1:0] dst;
    logic [AGE_W-1:0] age;
  } entry_t;

  entry_t ent [DEPTH];

  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] freeMask;
  logic             freeDo;
  logic [AGE_W-1:0] freeAge;
  logic [AGE_W-1:0] newAge;
  logic             dispWakeL, dispWakeR;

  assign grantDst = ent[strobe.grantSlot].dst;
  assign freeDo   = freeValid && ent[freeSlot].valid;
  assign freeAge  = ent[freeSlot].age;
  assign freeMask = freeDo ? (DEPTH'(1) << freeSlot) : '0;
  assign newAge   = AGE_W'($countones(validVec & ~freeMask));

  assign dispWakeL = (bcastValid && dispSrcL == bcastTag) ||
                     (strobe.grantValid && dispSrcL == grantDst);
  assign dispWakeR = (bcastValid && dispSrcR == bcastTag) ||
                     (strobe.grantValid && dispSrcR == grantDst);

  for (genvar i = 0; i < DEPTH; i++) begin : gEnt
    logic wakeL, wakeR, hitDisp, hitFree, hitGrant;

    assign wakeL    = (bcastValid && ent[i].srcL == bcastTag) ||
                      (strobe.grantValid && ent[i].srcL == grantDst);
    assign wakeR    = (bcastValid && ent[i].srcR == bcastTag) ||
                      (strobe.grantValid && ent[i].srcR == grantDst);
    assign hitDisp  = dispValid && dispSlot == SLOT_W'(i);
    assign hitFree  = freeDo && freeSlot == SLOT_W'(i);
    assign hitGrant = strobe.grantValid && strobe.grantSlot == SLOT_W'(i);

    assign validVec[i] = ent[i].valid;
    assign ageVec[i]   = ent[i].age;
    assign bidVec[i]   = ent[i].valid && !ent[i].issued && ent[i].rdyL && ent[i].rdyR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[i] <= '0;
      end else if (hitDisp) begin
        ent[i].valid  <= 1'b1;
        ent[i].issued <= 1'b0;
        ent[i].srcL   <= dispSrcL;
        ent[i].srcR   <= dispSrcR;
        ent[i].rdyL   <= dispRdyL || dispWakeL;
        ent[i].rdyR   <= dispRdyR || dispWakeR;
        ent[i].dst    <= dispDst;
        ent[i].age    <= newAge;
      end else if (hitFree) begin
        ent[i].valid  <= 1'b0;
      end else if (ent[i].valid) begin
        if (wakeL)    ent[i].rdyL   <= 1'b1;
        if (wakeR)    ent[i].rdyR   <= 1'b1;
        if (hitGrant) ent[i].issued <= 1'b1;
        if (freeDo && ent[i].age > freeAge) ent[i].age <= ent[i].age - 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int DEPTH = IQ_DEPTH
) (
  input  logic [DEPTH-1:0]             bidVec,
  input  logic [DEPTH-1:0][AGE_W-1:0]  ageVec,
  output iqStrobe_t                    strobe
);
  logic [DEPTH-1:0] winVec;

  // a bidder wins when no other bidder carries a lower age
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      winVec[i] = bidVec[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (bidVec[j] && ageVec[j] < ageVec[i]) winVec[i] = 1'b0;
      end
    end
  end

  always_comb begin
    strobe.grantValid = |bidVec;
    strobe.grantSlot  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (winVec[i]) strobe.grantSlot = strobe.grantSlot | SLOT_W'(i);
    end
  end
endmodule

// File: rtl/wakeup_select_iq.sv
module wakeup_select_iq
  import iq_pkg::*;
#(
  parameter int DEPTH = IQ_DEPTH,
  parameter int TAG_W = IQ_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dispValid,
  input  logic [SLOT_W-1:0] dispSlot,
  input  logic [TAG_W-1:0]  dispSrcL,
  input  logic              dispRdyL,
  input  logic [TAG_W-1:0]  dispSrcR,
  input  logic              dispRdyR,
  input  logic [TAG_W-1:0]  dispDst,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic              freeValid,
  input  logic [SLOT_W-1:0] freeSlot,
  output logic              issueValid,
  output logic [SLOT_W-1:0] issueSlot,
  output logic [TAG_W-1:0]  issueDst
);
  iqStrobe_t                   strobe;
  logic [DEPTH-1:0]            bidVec;
  logic [DEPTH-1:0][AGE_W-1:0] ageVec;
  logic [TAG_W-1:0]            grantDst;

  iq_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uEntries (
    .clk(clk), .rst_n(rst_n),
    .dispValid(dispValid), .dispSlot(dispSlot),
    .dispSrcL(dispSrcL), .dispRdyL(dispRdyL),
    .dispSrcR(dispSrcR), .dispRdyR(dispRdyR), .dispDst(dispDst),
    .bcastValid(bcastValid), .bcastTag(bcastTag),
    .freeValid(freeValid), .freeSlot(freeSlot),
    .strobe(strobe), .bidVec(bidVec), .ageVec(ageVec), .grantDst(grantDst)
  );

  iq_select #(.DEPTH(DEPTH)) uSelect (
    .bidVec(bidVec), .ageVec(ageVec), .strobe(strobe)
  );

  assign issueValid = strobe.grantValid;
  assign issueSlot  = strobe.grantSlot;
  assign issueDst   = strobe.grantValid ? grantDst : '0;
endmodule

// File: rtl/iq_checker.sv
module iq_checker
  import iq_pkg::*;
#(
  parameter int DEPTH = IQ_DEPTH,
  parameter int TAG_W = IQ_TAG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dispValid,
  input logic [SLOT_W-1:0] dispSlot,
  input logic              dispRdyL,
  input logic              dispRdyR,
  input logic              freeValid,
  input logic [SLOT_W-1:0] freeSlot,
  input logic              issueValid,
  input logic [SLOT_W-1:0] issueSlot,
  input logic [TAG_W-1:0]  issueDst
);
  logic [DEPTH-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else begin
      if (freeValid) occ[freeSlot] <= 1'b0;
      if (dispValid) occ[dispSlot] <= 1'b1;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |-> (issueSlot == '0 && issueDst == '0)); // R11

  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !(dispValid && dispSlot == issueSlot))
      |=> !(issueValid && issueSlot == $past(issueSlot))); // R7

  AST_GRANT_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> occ[issueSlot]); // R10

  AST_READY_DISPATCH_BIDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid && dispRdyL && dispRdyR && !issueValid) |=> issueValid); // R2
endmodule

bind wakeup_select_iq iq_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uChecker (.*);

// File: tb/wakeup_select_iq_test.sv
module wakeup_select_iq_test;
  typedef struct packed {
    logic       dv;
    logic [2:0] ds;
    logic [5:0] sl;
    logic       rl;
    logic [5:0] sr;
    logic       rr;
    logic [5:0] dd;
    logic       bv;
    logic [5:0] bt;
    logic       fv;
    logic [2:0] fs;
    logic       ev;
    logic [2:0] es;
    logic [5:0] ed;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t row(int dv, int ds, int sl, int rl, int sr, int rr, int dd,
                               int bv, int bt, int fv, int fs,
                               int ev, int es, int ed, int rq);
    vec_t v;
    v.dv = dv[0]; v.ds = ds[2:0]; v.sl = sl[5:0]; v.rl = rl[0];
    v.sr = sr[5:0]; v.rr = rr[0]; v.dd = dd[5:0];
    v.bv = bv[0]; v.bt = bt[5:0]; v.fv = fv[0]; v.fs = fs[2:0];
    v.ev = ev[0]; v.es = es[2:0]; v.ed = ed[5:0]; v.rq = rq[3:0];
    return v;
  endfunction

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    row(1,5, 0,1, 0,1,10, 0, 0, 0,0, 1,5,10, 2),  // R2 ready dispatch bids
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0, 7),  // R7 granted, not again
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0, 7),  // R7
    row(1,2,20,0,21,1,11, 0, 0, 0,0, 0,0, 0, 3),  // R3 waits on tag 20
    row(0,0, 0,0, 0,0, 0, 1,22, 0,0, 0,0, 0, 3),  // R3 non-matching tag
    row(1,0,30,0,20,0,12, 1,20, 0,0, 1,2,11, 3),  // R3 wake slot2; R9 capture
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0, 4),  // R4 slot0 half ready
    row(0,0, 0,0, 0,0, 0, 1,30, 0,0, 1,0,12, 9),  // R9 captured right op
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0, 7),  // R7
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,5, 0,0, 0,10),  // R10 free
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,2, 0,0, 0,10),  // R10
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,0, 0,0, 0,10),  // R10
    row(1,7,40,0,41,1,13, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(1,3,40,0,41,1,14, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(1,6,40,0,41,1,15, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(0,0, 0,0, 0,0, 0, 1,40, 0,0, 1,7,13, 5),  // R5 oldest at slot 7
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 1,3,14, 6),  // R6 loser retries
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 1,6,15, 6),  // R6
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0,11),  // R11 idle
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,3, 0,0, 0,10),  // R10
    row(1,1,50,0,51,1,17, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(1,3, 9,1, 9,1,50, 0, 0, 0,0, 1,3,50, 2),  // R2 producer
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 1,1,17, 8),  // R8 back-to-back wakeup
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0,11),  // R11
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,7, 0,0, 0,10),  // R10
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,6, 0,0, 0,10),  // R10
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,1, 0,0, 0,10),  // R10
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,3, 0,0, 0,10),  // R10
    row(1,4,60,0, 1,1,20, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(1,0,61,0, 1,1,21, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(1,2,60,0, 1,1,22, 0, 0, 0,0, 0,0, 0, 3),  // R3
    row(0,0, 0,0, 0,0, 0, 0, 0, 1,0, 0,0, 0,10),  // R10 free middle
    row(1,0,60,0, 1,1,23, 0, 0, 0,0, 0,0, 0, 3),  // R3 youngest at slot 0
    row(0,0, 0,0, 0,0, 0, 1,60, 0,0, 1,4,20, 5),  // R5
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 1,2,22,10),  // R10 slot2 older than slot0
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 1,0,23,10),  // R10
    row(0,0, 0,0, 0,0, 0, 0, 0, 0,0, 0,0, 0,11)   // R11
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dispValid = 1'b0;
  logic [2:0] dispSlot = '0;
  logic [5:0] dispSrcL = '0;
  logic       dispRdyL = 1'b0;
  logic [5:0] dispSrcR = '0;
  logic       dispRdyR = 1'b0;
  logic [5:0] dispDst = '0;
  logic       bcastValid = 1'b0;
  logic [5:0] bcastTag = '0;
  logic       freeValid = 1'b0;
  logic [2:0] freeSlot = '0;
  logic       issueValid;
  logic [2:0] issueSlot;
  logic [5:0] issueDst;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  wakeup_select_iq uut (
    .clk(clk), .rst_n(rst_n),
    .dispValid(dispValid), .dispSlot(dispSlot),
    .dispSrcL(dispSrcL), .dispRdyL(dispRdyL),
    .dispSrcR(dispSrcR), .dispRdyR(dispRdyR), .dispDst(dispDst),
    .bcastValid(bcastValid), .bcastTag(bcastTag),
    .freeValid(freeValid), .freeSlot(freeSlot),
    .issueValid(issueValid), .issueSlot(issueSlot), .issueDst(issueDst)
  );

  task automatic checkOut(input int rq, input logic ev, input logic [2:0] es, input logic [5:0] ed);
    nChecks++;
    if (issueValid !== ev || issueSlot !== es || issueDst !== ed) begin
      nFails++;
      $display("FAIL R%0d: got valid=%0b slot=%0d dst=%0d, expected valid=%0b slot=%0d dst=%0d",
               rq, issueValid, issueSlot, issueDst, ev, es, ed);
    end
  endtask

  task automatic apply(input vec_t v);
    dispValid = v.dv; dispSlot = v.ds; dispSrcL = v.sl; dispRdyL = v.rl;
    dispSrcR = v.sr; dispRdyR = v.rr; dispDst = v.dd;
    bcastValid = v.bv; bcastTag = v.bt; freeValid = v.fv; freeSlot = v.fs;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut(1, 1'b0, 3'd0, 6'd0);  // R1 quiet in reset
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checkOut(1, 1'b0, 3'd0, 6'd0);  // R1 empty after reset

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      checkOut(int'(VECS[k].rq), VECS[k].ev, VECS[k].es, VECS[k].ed);
    end

    // R2: fresh ready dispatch into an empty slot, then reset mid-run
    apply(row(1,5, 0,1, 0,1,33, 0,0, 0,0, 0,0,0, 2));
    checkOut(2, 1'b1, 3'd5, 6'd33);
    rst_n = 1'b0;
    #1;
    checkOut(1, 1'b0, 3'd0, 6'd0);  // R1 reset in mid-operation
    apply(row(0,0,0,0,0,0,0, 0,0, 0,0, 0,0,0, 1));
    rst_n = 1'b1;
    apply(row(0,0,0,0,0,0,0, 0,0, 0,0, 0,0,0, 1));
    checkOut(1, 1'b0, 3'd0, 6'd0);  // R1 bidder gone after reset

    finishRun();
  end
endmodule